// File: doc/BRIEF.md
# Dual-Clock FIFO with Occupancy Flags

This block is a first-in first-out buffer that lets a producer on one free-running clock hand words to a consumer on another, unrelated clock. Write and read positions are kept as binary counters one bit wider than the address. Each position is carried to the opposite domain in Gray code through a parameterised chain of synchronizer flops. Storage is an inferred dual-port array of `2**ADDR_W` words.

Each side sees its own occupancy picture: a word count, exact full or empty, a one-word-margin warning, and a threshold flag with inclusive comparison. Each side also gets per-cycle reports on what happened to the previous request: accepted, dropped because full, or dropped because empty. Reads are in standard mode: a word appears on `dout` one read-clock cycle after an accepted request, marked by `rd_valid`.

A single reset input, synchronous to the write clock, clears both sides. Each side shows a busy output until its own reset is complete. The write side stays busy until the read side has left reset.

Top module: `dcfifo_flags`

## Requirements
- R1: Words leave in the order they were accepted. After a read request that is accepted (`rd_en` high, `empty` low, `rd_busy` low) at a read-clock edge, `rd_valid` is high and `dout` carries the word during the following read-clock cycle.
- R2: A write request made while `full` is high is dropped, and the stored words are unchanged. `overflow` is high during the next write-clock cycle, and `wr_ack` stays low.
- R3: A read request made while `empty` is high is dropped. `underflow` is high during the next read-clock cycle, and `rd_valid` stays low.
- R4: `wr_ack` is high during the write-clock cycle after each accepted write.
- R5: `full` is high when `2**ADDR_W` words are held as seen from the write side. `empty` is high when no words are held as seen from the read side.
- R6: `almost_full` is high only when exactly `2**ADDR_W - 1` words are held. `almost_empty` is high only when exactly one word is held.
- R7: `prog_full` is high while the held word count is greater than or equal to `PFULL_LVL`.
- R8: `prog_empty` is high while the held word count is less than or equal to `PEMPTY_LVL`.
- R9: `wr_count` and `rd_count` equal the held word count once both sides have been idle for `SYNC_STAGES + 3` cycles of each clock.
- R10: While `rst` is high, `wr_busy` is high, and `rd_busy` rises within `SYNC_STAGES + 1` read-clock cycles. After both busy outputs fall, the FIFO is empty, with both counts zero, `empty` high and `full` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rst | input | 1 | Reset, synchronous to `wclk`, active high |
| wr_en | input | 1 | Write request |
| din | input | DATA_W | Write data |
| full | output | 1 | No room for another word |
| almost_full | output | 1 | Room for exactly one word |
| prog_full | output | 1 | Count at or above `PFULL_LVL` |
| wr_ack | output | 1 | Previous write accepted |
| overflow | output | 1 | Previous write dropped because full |
| wr_busy | output | 1 | Write side in reset |
| wr_count | output | ADDR_W+1 | Occupancy seen from the write side |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| dout | output | DATA_W | Read data |
| empty | output | 1 | No word held |
| almost_empty | output | 1 | Exactly one word held |
| prog_empty | output | 1 | Count at or below `PEMPTY_LVL` |
| rd_valid | output | 1 | `dout` carries a word this cycle |
| underflow | output | 1 | Previous read dropped because empty |
| rd_busy | output | 1 | Read side in reset |
| rd_count | output | ADDR_W+1 | Occupancy seen from the read side |

## Verification
`wr_ack` and `overflow` are registered at the write-clock edge that sees the request, so the bench samples them at the next falling write-clock edge. `rd_valid`, `dout` and `underflow` follow the same rule in the read domain. Flags and counts that depend on the opposite side's position become valid only after the synchronizer chain has passed it across. The bench therefore idles both clocks for `SYNC_STAGES + 3` cycles after each burst before comparing them. Only flags that depend solely on the local pointer, such as `full` after writes with no reads in progress, are sampled in the cycle right after the request.

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PFULL_LVL   = 12,
  parameter int PEMPTY_LVL  = 3
) (
  input  logic              wclk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  output logic              full,
  output logic              almost_full,
  output logic              prog_full,
  output logic              wr_ack,
  output logic              overflow,
  output logic              wr_busy,
  output logic [ADDR_W:0]   wr_count,
  input  logic              rclk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              almost_empty,
  output logic              prog_empty,
  output logic              rd_valid,
  output logic              underflow,
  output logic              rd_busy,
  output logic [ADDR_W:0]   rd_count
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0]      mem [DEPTH];
  logic [PW-1:0]          wptr, rptr, wgray, rgray;
  logic [PW-1:0]          rg_sync [SYNC_STAGES];
  logic [PW-1:0]          wg_sync [SYNC_STAGES];
  logic [SYNC_STAGES-1:0] rst_to_r, busy_to_w;
  logic                   wseen;

  wire [PW-1:0] wnext = wptr + PW'(1);
  wire [PW-1:0] rnext = rptr + PW'(1);
  wire          wr_go = wr_en & ~full & ~wr_busy;
  wire          rd_go = rd_en & ~empty & ~rd_busy;
  wire [PW-1:0] rg_far = rg_sync[SYNC_STAGES-1];
  wire [PW-1:0] wg_far = wg_sync[SYNC_STAGES-1];

  // write domain
  assign full        = (wgray == {~rg_far[PW-1:PW-2], rg_far[PW-3:0]});
  assign wr_count    = wptr - from_gray(rg_far);
  assign almost_full = (wr_count == PW'(DEPTH - 1));
  assign prog_full   = (wr_count >= PW'(PFULL_LVL));

  always_ff @(posedge wclk) begin
    if (rst) begin
      wptr     <= '0;
      wgray    <= '0;
      wr_ack   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      wr_ack   <= wr_go;
      overflow <= wr_en & full & ~wr_busy;
      if (wr_go) begin
        wptr  <= wnext;
        wgray <= to_gray(wnext);
      end
    end
  end

  always_ff @(posedge wclk)
    if (wr_go) mem[wptr[ADDR_W-1:0]] <= din;

  always_ff @(posedge wclk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) rg_sync[i] <= '0;
    end else begin
      rg_sync[0] <= rgray;
      for (int i = 1; i < SYNC_STAGES; i++) rg_sync[i] <= rg_sync[i-1];
    end
  end

  always_ff @(posedge wclk) begin
    busy_to_w <= {busy_to_w[SYNC_STAGES-2:0], rd_busy};
    if (rst) begin
      wr_busy <= 1'b1;
      wseen   <= 1'b0;
    end else if (wr_busy) begin
      if (busy_to_w[SYNC_STAGES-1]) wseen <= 1'b1;
      else if (wseen)               wr_busy <= 1'b0;
    end
  end

  // read domain
  always_ff @(posedge rclk)
    rst_to_r <= {rst_to_r[SYNC_STAGES-2:0], rst};

  assign rd_busy      = rst_to_r[SYNC_STAGES-1];
  assign empty        = (rgray == wg_far);
  assign rd_count     = from_gray(wg_far) - rptr;
  assign almost_empty = (rd_count == PW'(1));
  assign prog_empty   = (rd_count <= PW'(PEMPTY_LVL));

  always_ff @(posedge rclk) begin
    if (rd_busy) begin
      rptr      <= '0;
      rgray     <= '0;
      rd_valid  <= 1'b0;
      underflow <= 1'b0;
      dout      <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) wg_sync[i] <= '0;
    end else begin
      rd_valid  <= rd_go;
      underflow <= rd_en & empty;
      if (rd_go) begin
        dout  <= mem[rptr[ADDR_W-1:0]];
        rptr  <= rnext;
        rgray <= to_gray(rnext);
      end
      wg_sync[0] <= wgray;
      for (int i = 1; i < SYNC_STAGES; i++) wg_sync[i] <= wg_sync[i-1];
    end
  end
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int ADDR_W = 4
) (
  input logic            wclk,
  input logic            rclk,
  input logic            rst,
  input logic            rd_busy,
  input logic            wr_en,
  input logic            rd_en,
  input logic            full,
  input logic            empty,
  input logic            almost_full,
  input logic            wr_ack,
  input logic            overflow,
  input logic            underflow,
  input logic            rd_valid,
  input logic [ADDR_W:0] wr_count,
  input logic [ADDR_W:0] wptr,
  input logic [ADDR_W:0] rptr
);
  localparam int DEPTH = 1 << ADDR_W;

  p_full_hold_r2: assert property (@(posedge wclk) disable iff (rst)
    full |=> $stable(wptr));
  p_ovf_cause_r2: assert property (@(posedge wclk) disable iff (rst)
    overflow |-> $past(wr_en && full));
  p_ack_cause_r4: assert property (@(posedge wclk) disable iff (rst)
    wr_ack |-> $past(wr_en && !full));
  p_ack_ovf_excl_r4: assert property (@(posedge wclk) disable iff (rst)
    !(wr_ack && overflow));
  p_empty_hold_r3: assert property (@(posedge rclk) disable iff (rst || rd_busy)
    empty |=> $stable(rptr));
  p_unf_cause_r3: assert property (@(posedge rclk) disable iff (rst || rd_busy)
    underflow |-> $past(rd_en && empty));
  p_valid_cause_r1: assert property (@(posedge rclk) disable iff (rst || rd_busy)
    rd_valid |-> $past(rd_en && !empty));
  p_afull_excl_r6: assert property (@(posedge wclk) disable iff (rst)
    !(full && almost_full));
  p_count_bound_r9: assert property (@(posedge wclk) disable iff (rst)
    wr_count <= (ADDR_W+1)'(DEPTH));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .rd_busy(rd_busy),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty),
  .almost_full(almost_full), .wr_ack(wr_ack), .overflow(overflow),
  .underflow(underflow), .rd_valid(rd_valid), .wr_count(wr_count),
  .wptr(wptr), .rptr(rptr)
);

// File: tb/test_dcfifo_flags.sv
module test_dcfifo_flags;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
  localparam int DW = 8, AW = 4, SYNC = 2, PF = 12, PE = 3;
  localparam int DEPTH = 1 << AW;

  // {writes, reads, count, flags}; flags bit7 full, 6 afull, 5 pfull, 4 empty, 3 aempty, 2 pempty
  localparam logic [31:0] VEC [12] = '{
    32'h01_00_01_0C, 32'h02_00_03_04, 32'h01_00_04_00, 32'h08_00_0C_20,
    32'h03_00_0F_60, 32'h01_00_10_A0, 32'h00_01_0F_60, 32'h00_04_0B_00,
    32'h00_07_04_00, 32'h00_01_03_04, 32'h00_02_01_0C, 32'h00_01_00_14
  };

  logic wclk = 0, rclk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [DW-1:0] din = '0, dout;
  logic full, almost_full, prog_full, wr_ack, overflow, wr_busy;
  logic empty, almost_empty, prog_empty, rd_valid, underflow, rd_busy;
  logic [AW:0] wr_count, rd_count;

  int checks = 0, fails = 0;
  logic [DW-1:0] sb [$];
  logic [DW-1:0] wdat = 8'h10;
  bit done = 0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dcfifo_flags #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC),
                 .PFULL_LVL(PF), .PEMPTY_LVL(PE)) i_dcfifo_flags (
    .wclk(wclk), .rst(rst), .wr_en(wr_en), .din(din), .full(full),
    .almost_full(almost_full), .prog_full(prog_full), .wr_ack(wr_ack),
    .overflow(overflow), .wr_busy(wr_busy), .wr_count(wr_count),
    .rclk(rclk), .rd_en(rd_en), .dout(dout), .empty(empty),
    .almost_empty(almost_empty), .prog_empty(prog_empty), .rd_valid(rd_valid),
    .underflow(underflow), .rd_busy(rd_busy), .rd_count(rd_count));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_word();
    @(negedge wclk); wr_en = 1; din = wdat;
    @(negedge wclk); wr_en = 0;
    chk("R4 wr_ack after accepted write", wr_ack, 1);
    sb.push_back(wdat);
    wdat++;
  endtask

  task automatic pop_word();
    logic [DW-1:0] e;
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
    e = sb.pop_front();
    chk("R1 rd_valid", rd_valid, 1);
    chk("R1 dout order", dout, e);
  endtask

  task automatic settle();
    repeat (SYNC + 3) @(negedge rclk);
    repeat (SYNC + 3) @(negedge wclk);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (10) @(negedge wclk);
    chk("R10 wr_busy in reset", wr_busy, 1);
    chk("R10 rd_busy in reset", rd_busy, 1);
    rst = 0;
    while (wr_busy || rd_busy) @(negedge wclk);
    sb.delete();
    settle();
    chk("R10 empty after reset", empty, 1);
    chk("R10 full after reset", full, 0);
    chk("R10 wr_count after reset", wr_count, 0);
    chk("R10 rd_count after reset", rd_count, 0);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();

    foreach (VEC[k]) begin
      for (int i = 0; i < int'(VEC[k][31:24]); i++) push_word();
      for (int i = 0; i < int'(VEC[k][23:16]); i++) pop_word();
      settle();
      chk("R9 wr_count", wr_count, int'(VEC[k][15:8]));
      chk("R9 rd_count", rd_count, int'(VEC[k][15:8]));
      chk("R5 full", full, VEC[k][7]);
      chk("R6 almost_full", almost_full, VEC[k][6]);
      chk("R7 prog_full", prog_full, VEC[k][5]);
      chk("R5 empty", empty, VEC[k][4]);
      chk("R6 almost_empty", almost_empty, VEC[k][3]);
      chk("R8 prog_empty", prog_empty, VEC[k][2]);
    end

    // R2: write while full
    for (int i = 0; i < DEPTH; i++) push_word();
    chk("R5 full right after last write", full, 1);
    @(negedge wclk); wr_en = 1; din = 8'hEE;
    @(negedge wclk); wr_en = 0;
    chk("R2 overflow", overflow, 1);
    chk("R4 no wr_ack on dropped write", wr_ack, 0);
    @(negedge wclk);
    chk("R2 overflow clears", overflow, 0);
    chk("R2 count unchanged", wr_count, DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_word();
    settle();
    chk("R5 empty after drain", empty, 1);

    // R3: read while empty
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
    chk("R3 underflow", underflow, 1);
    chk("R3 no rd_valid", rd_valid, 0);
    @(negedge rclk);
    chk("R3 underflow clears", underflow, 0);
    chk("R3 rd_count stays zero", rd_count, 0);
    push_word();
    settle();
    pop_word();

    // R10: reset with words held
    for (int i = 0; i < 5; i++) push_word();
    settle();
    chk("R9 count before reset", rd_count, 5);
    do_reset();
    push_word();
    settle();
    pop_word();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule